// File: doc/BRIEF.md
# Queued Quad-SPI Phase Sequencer

This block is a serial flash master. It runs a whole flash transaction from a queue of phase entries. An entry is one of four kinds: an immediate transmit byte, a receive burst, a dummy stretch, or an entry with no kind bit, which runs as dummy. Each entry also names the number of lanes it uses, which is one, two or four. Entries are pushed into a 16-deep queue through a valid/ready port. Pushing an entry never starts anything.

A one-cycle start pulse opens chip select. The queued entries then run back to back with no idle clock between them. The run goes on until the queue is empty or until an entry without its chip-select-hold bit finishes. Entries left in the queue wait for the next start.

The block drives the serial clock in mode 0. Outputs change on the falling edge and inputs are sampled on the rising edge. The four IO lanes have separate output values and output enables. The direction each entry needs is applied at the falling edge that closes the previous entry's last clock. A read that follows a dummy stretch therefore already has its lanes released half a clock before its first sample.

Received bytes leave on a valid/ready stream. A byte stays on `rx_data` with `rx_valid` high until `rx_ready` takes it. While a byte waits, the serial clock freezes at its present level, so back-pressure never drops data.

Top module: `qspi_phase_seq`

## Requirements
- R1: Pushing entries (word bits [7:0] argument, [9:8] lane code 01 = one lane, 10 = two, 11 = four, bit 10 transmit, bit 11 receive, bit 12 dummy, bit 13 chip-select hold) never lowers `cs_n`. `ent_ready` is low once 16 entries are queued.
- R2: A start pulse while idle with a non-empty queue lowers `cs_n` and raises `busy` at the next edge. The first rising `sclk` edge comes `clk_div/2` cycles later, and rising edges then repeat every `clk_div` cycles with no gap between entries.
- R3: A transmit entry runs 8/w clocks. Receive and dummy entries run N·8/w clocks, where N is the argument (0 means 256) and w is the lane count.
- R4: Transmit sends the argument MSB first. One lane: IO0 carries the bit and IO1 is released (enables 1101). Two lanes: IO1 carries the higher bit and all lanes are driven. Four lanes: IO3 carries bit 3. Lanes not used for data are driven with IO2 = IO3 = 1.
- R5: Receive samples on rising `sclk`, MSB first. It reads IO1 in one-lane mode, IO1:IO0 in two-lane mode and IO3:IO0 in four-lane mode, and delivers one byte after every 8/w clocks.
- R6: Dummy and receive entries release the lanes of their width. One lane: IO0 = 0, IO2 = IO3 = 1 driven, IO1 released. Two lanes: IO1:IO0 released, IO2 and IO3 driven high. Four lanes: all released. Input during dummy produces no byte.
- R7: An entry's direction is already on the pins at the falling edge that ends the previous entry's last clock.
- R8: At reset and whenever `cs_n` is high: `sclk` = 0, `busy` = 0, enables = 1101, IO0 = 0, IO2 = IO3 = 1.
- R9: `cs_n` rises `clk_div` cycles after the final falling edge, and `busy` falls with it. `cs_n` stays low for (clocks + 1)·`clk_div` cycles.
- R10: An entry with bit 13 clear ends the run after itself. Later entries wait for another start.
- R11: While `rx_valid` is high and `rx_ready` is low, `rx_data` holds and `sclk` does not change. No byte is lost.
- R12: A start pulse while busy, or with an empty queue, has no effect.
- R13: Kind priority is dummy over receive over transmit, and an entry with no kind bit runs as dummy. Lane code 00 acts as one lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Even divisor from system clock to `sclk` |
| ent_valid | input | 1 | Entry word offered |
| ent_ready | output | 1 | Queue has room |
| ent_word | input | 14 | Entry word |
| start | input | 1 | Start pulse |
| busy | output | 1 | Run in progress |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Received byte |

## Verification
A wrong clock-remaining count or a wrong kind decode shows up one `sclk` period later as an extra or missing rising edge, or as the wrong enable pattern on the pins. The bench's per-clock model catches this at the first wrong edge. A wrong beat counter or shift width shows up as a wrong byte, or a byte at the wrong time, at the `rx_data` handshake. A direction that is applied late shows up at the falling edge that closes the previous entry, half a clock before the first read sample. A broken stall shows up as an `sclk` change in the very cycle after a byte went unaccepted.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int ENTRY_W = 14;

  typedef enum logic [1:0] {
    LN_NONE = 2'b00,
    LN_X1   = 2'b01,
    LN_X2   = 2'b10,
    LN_X4   = 2'b11
  } lane_code_e;

  typedef enum logic [1:0] {
    PK_TX    = 2'd0,
    PK_RX    = 2'd1,
    PK_DUMMY = 2'd2
  } phase_kind_e;

  typedef struct packed {
    logic       cs_hold;
    logic       is_dummy;
    logic       is_rx;
    logic       is_tx;
    lane_code_e lanes;
    logic [7:0] arg;
  } entry_t;

  // log2 of the lane count; code 00 falls back to one lane (R13)
  function automatic logic [1:0] lane_shift(lane_code_e c);
    case (c)
      LN_X2:   return 2'd1;
      LN_X4:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // dummy > receive > transmit, nothing set runs as dummy (R13)
  function automatic phase_kind_e decode_kind(entry_t e);
    if (e.is_dummy) return PK_DUMMY;
    if (e.is_rx)    return PK_RX;
    if (e.is_tx)    return PK_TX;
    return PK_DUMMY;
  endfunction
endpackage

// File: rtl/qps_entry_fifo.sv
module qps_entry_fifo #(
  parameter int WIDTH = 14,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/qps_sclk_gen.sv
module qps_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             stall,
  input  logic             quiet,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] half, cnt;
  logic             lvl, tick;

  assign half     = (div < DIV_W'(2)) ? DIV_W'(1) : (div >> 1);
  assign tick     = run && !stall && (cnt == '0);
  assign rise_evt = tick && !lvl;
  assign fall_evt = tick && lvl;
  assign sclk     = lvl && !quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (restart) begin
      cnt <= half - DIV_W'(1);
      lvl <= 1'b0;
    end else if (!run) begin
      lvl <= 1'b0;
    end else if (tick) begin
      cnt <= half - DIV_W'(1);
      lvl <= !lvl;
    end else if (!stall) begin
      cnt <= cnt - DIV_W'(1);
    end
  end
endmodule

// File: rtl/qps_lane_drive.sv
module qps_lane_drive
  import qps_pkg::*;
(
  input  logic        active,
  input  phase_kind_e kind,
  input  logic [1:0]  lsh,
  input  logic [3:0]  tx_nib,
  output logic [3:0]  oe,
  output logic [3:0]  out
);
  always_comb begin
    oe  = 4'b1101;
    out = 4'b1100;
    if (active) begin
      if (kind == PK_TX) begin
        case (lsh)
          2'd0:    begin oe = 4'b1101; out = {3'b110, tx_nib[3]}; end
          2'd1:    begin oe = 4'b1111; out = {2'b11, tx_nib[3:2]}; end
          default: begin oe = 4'b1111; out = tx_nib; end
        endcase
      end else begin
        case (lsh)
          2'd0:    begin oe = 4'b1101; out = 4'b1100; end
          2'd1:    begin oe = 4'b1100; out = 4'b1100; end
          default: begin oe = 4'b0000; out = 4'b0000; end
        endcase
      end
    end
  end
endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
  import qps_pkg::*;
#(
  parameter int QUEUE_DEPTH = 16,
  parameter int DIV_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic               ent_valid,
  output logic               ent_ready,
  input  logic [ENTRY_W-1:0] ent_word,
  input  logic               start,
  output logic               busy,
  output logic               cs_n,
  output logic               sclk,
  output logic [3:0]         io_out,
  output logic [3:0]         io_oe,
  input  logic [3:0]         io_in,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [7:0]         rx_data
);
  localparam int CLK_W = 8 + 1 + 3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_e;

  st_e              state;
  entry_t           head;
  logic             q_full, q_empty, pop, start_ok, run_end;
  logic             rise_evt, fall_evt, stall;
  phase_kind_e      kind, hd_kind;
  logic [1:0]       lsh, hd_lsh;
  logic             hold;
  logic [CLK_W-1:0] clk_left, hd_clks;
  logic [8:0]       hd_bytes;
  logic [2:0]       beat, beat_last;
  logic [7:0]       tx_sh, rx_sh, rx_next;

  assign ent_ready = !q_full;
  assign cs_n      = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign start_ok  = (state == S_IDLE) && start && !q_empty;
  assign run_end   = q_empty || !hold;
  assign pop       = start_ok ||
                     ((state == S_RUN) && fall_evt && (clk_left == '0) && !run_end);
  assign stall     = rx_valid && !rx_ready && (state == S_RUN);

  qps_entry_fifo #(.WIDTH(ENTRY_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(ent_valid), .wdata(ent_word),
    .pop(pop), .rdata(head), .full(q_full), .empty(q_empty)
  );

  qps_sclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(state != S_IDLE), .restart(start_ok),
    .stall(stall), .quiet(state == S_TAIL), .div(clk_div),
    .sclk(sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  qps_lane_drive u_lanes (
    .active(state != S_IDLE), .kind(kind), .lsh(lsh), .tx_nib(tx_sh[7:4]),
    .oe(io_oe), .out(io_out)
  );

  // decode of the queue head, applied when it is popped
  assign hd_kind  = decode_kind(head);
  assign hd_lsh   = lane_shift(head.lanes);
  assign hd_bytes = (hd_kind == PK_TX) ? 9'd1 :
                    (head.arg == 8'd0) ? 9'd256 : {1'b0, head.arg};
  assign hd_clks  = CLK_W'({hd_bytes, 3'b000} >> hd_lsh);

  always_comb begin
    case (lsh)
      2'd0:    begin rx_next = {rx_sh[6:0], io_in[1]};   beat_last = 3'd7; end
      2'd1:    begin rx_next = {rx_sh[5:0], io_in[1:0]}; beat_last = 3'd3; end
      default: begin rx_next = {rx_sh[3:0], io_in};      beat_last = 3'd1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind     <= PK_DUMMY;
      lsh      <= 2'd0;
      hold     <= 1'b0;
      clk_left <= '0;
      beat     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      case (state)
        S_IDLE: if (start_ok) state <= S_RUN;
        S_RUN: begin
          if (rise_evt) begin
            clk_left <= clk_left - CLK_W'(1);
            if (kind == PK_RX) begin
              rx_sh <= rx_next;
              if (beat == beat_last) begin
                beat     <= '0;
                rx_data  <= rx_next;
                rx_valid <= 1'b1;
              end else begin
                beat <= beat + 3'd1;
              end
            end
          end
          if (fall_evt) begin
            if (clk_left != '0) begin
              case (lsh)
                2'd0:    tx_sh <= tx_sh << 1;
                2'd1:    tx_sh <= tx_sh << 2;
                default: tx_sh <= tx_sh << 4;
              endcase
            end else if (run_end) begin
              state <= S_TAIL;
            end
          end
        end
        default: if (fall_evt) state <= S_IDLE;
      endcase

      if (pop) begin
        kind     <= hd_kind;
        lsh      <= hd_lsh;
        hold     <= head.cs_hold;
        clk_left <= hd_clks;
        beat     <= '0;
        tx_sh    <= head.arg;
      end
    end
  end
endmodule

// File: rtl/qspi_phase_seq_chk.sv
module qspi_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic [3:0] io_out,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R8

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b1101 && !io_out[0] && io_out[3:2] == 2'b11)); // R8

  AST_CS_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start)); // R1

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R11

  AST_SCLK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(sclk)); // R11
endmodule

bind qspi_phase_seq qspi_phase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sclk(sclk),
  .io_oe(io_oe), .io_out(io_out), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/qspi_phase_seq_test.sv
module qspi_phase_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd4;
  logic        ent_valid = 1'b0;
  logic        ent_ready;
  logic [13:0] ent_word = '0;
  logic        start = 1'b0;
  logic        busy, cs_n, sclk;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = 4'h0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [7:0]  rx_data;

  always #2.5 clk = !clk;

  qspi_phase_seq uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .ent_valid(ent_valid),
    .ent_ready(ent_ready), .ent_word(ent_word), .start(start), .busy(busy),
    .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  typedef struct {
    logic [3:0] oe;
    logic [3:0] out;
    logic [3:0] din;
    string      tag;
  } beat_t;

  beat_t       exp_q[$];
  logic [7:0]  exp_rx[$];
  logic [13:0] ent_q[$];
  int n_chk = 0, n_bad = 0, cyc = 0, low_cnt = 0, run_h = 2;
  bit seen_first = 0, prev_sclk = 0, prev_stall = 0, done = 0;
  int rx_seed = 8'h3C;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (cyc > 150000) begin
        chk(0, "watchdog", cyc, 150000);
        finish_up();
      end
      if (cs_n) begin
        chk(!sclk && !busy && io_oe == 4'b1101 && !io_out[0] && io_out[3:2] == 2'b11,
            "R8 idle pins", {sclk, busy, io_oe, io_out}, {2'b00, 4'b1101, 4'b1100});
      end else begin
        low_cnt++;
        chk(busy, "R2 busy while selected", busy, 1);
      end
      if (prev_stall)
        chk(sclk == prev_sclk, "R11 sclk frozen", sclk, prev_sclk);
      if (!prev_sclk && sclk) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 extra clock", 1, 0);
        end else begin
          beat_t b;
          b = exp_q.pop_front();
          chk(io_oe == b.oe && (io_out & b.oe) == (b.out & b.oe),
              {b.tag, " lane pins"}, {io_oe, io_out}, {b.oe, b.out & b.oe});
          if (!seen_first)
            chk(low_cnt == run_h + 1, "R2 first edge delay", low_cnt, run_h + 1);
          seen_first = 1;
        end
        io_in = (exp_q.size() > 0) ? exp_q[0].din : 4'hA;
      end
      if (prev_sclk && !sclk && !cs_n && exp_q.size() > 0)
        chk(io_oe == exp_q[0].oe, "R7 direction at fall", io_oe, exp_q[0].oe);
      if (rx_valid && rx_ready) begin
        if (exp_rx.size() == 0) chk(0, "R6 unexpected byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          chk(rx_data == e, "R5 received byte", rx_data, e);
        end
      end
      prev_stall = rx_valid && !rx_ready;
      prev_sclk  = sclk;
    end
  end

  task automatic push_ent(input logic [13:0] w);
    @(posedge clk); #1;
    ent_valid = 1'b1;
    ent_word  = w;
    do @(negedge clk); while (!ent_ready);
    @(posedge clk); #1;
    ent_valid = 1'b0;
    ent_q.push_back(w);
  endtask

  function automatic logic [13:0] mk(input bit hold, input bit dm, input bit rx,
                                     input bit tx, input logic [1:0] ln,
                                     input logic [7:0] arg);
    return {hold, dm, rx, tx, ln, arg};
  endfunction

  // behavioural expansion of one entry into serial clocks
  task automatic expand(input logic [13:0] w, inout int n);
    int wd, nb, cpb, kind;
    wd   = (w[9:8] == 2'b10) ? 2 : (w[9:8] == 2'b11) ? 4 : 1;   // R13 code 00
    nb   = (w[7:0] == 0) ? 256 : int'(w[7:0]);
    kind = w[12] ? 2 : w[11] ? 1 : w[10] ? 0 : 2;               // R13 priority
    cpb  = 8 / wd;
    if (kind == 0) nb = 1;
    for (int by = 0; by < nb; by++) begin
      int val;
      val = int'(w[7:0]);
      if (kind == 1) begin
        val = rx_seed;
        rx_seed = (rx_seed * 37 + 11) & 255;
        exp_rx.push_back(8'(val));
      end
      for (int c = 0; c < cpb; c++) begin
        beat_t b;
        logic [3:0] bits;
        bits = 4'((val >> (8 - wd * (c + 1))) & ((1 << wd) - 1));
        if (kind == 0) begin
          b.tag = "R4";
          b.din = 4'h5;
          if (wd == 1)      begin b.oe = 4'b1101; b.out = {3'b110, bits[0]}; end
          else if (wd == 2) begin b.oe = 4'b1111; b.out = {2'b11, bits[1:0]}; end
          else              begin b.oe = 4'b1111; b.out = bits; end
        end else begin
          b.tag = (kind == 1) ? "R5" : "R6";
          if (wd == 1)      begin b.oe = 4'b1101; b.out = 4'b1100; end
          else if (wd == 2) begin b.oe = 4'b1100; b.out = 4'b1100; end
          else              begin b.oe = 4'b0000; b.out = 4'b0000; end
          if (kind == 2)      b.din = (c % 2 == 0) ? 4'hA : 4'h5;
          else if (wd == 1)   b.din = {2'b10, bits[0], 1'b1};
          else if (wd == 2)   b.din = {2'b01, bits[1:0]};
          else                b.din = bits;
        end
        exp_q.push_back(b);
        n++;
      end
    end
  endtask

  task automatic plan_run(output int n);
    n = 0;
    while (ent_q.size() > 0) begin
      logic [13:0] w;
      w = ent_q.pop_front();
      expand(w, n);
      if (!w[13]) break;   // R10 hold clear ends the run
    end
  endtask

  task automatic start_run(input int div, input bit chk_dur, input int poke,
                           input int release_at);
    int n, k;
    plan_run(n);
    clk_div = 8'(div);
    run_h = div / 2;
    if (exp_q.size() > 0) io_in = exp_q[0].din;
    seen_first = 0;
    low_cnt = 0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    k = 0;
    while (!cs_n && k < 60000) begin
      @(posedge clk); #1;
      k++;
      start = (k == poke);            // R12 start while busy
      if (k == release_at) rx_ready = 1'b1;
    end
    start = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, "R3 all clocks ran", exp_q.size(), 0);
    chk(exp_rx.size() == 0, "R5 all bytes delivered", exp_rx.size(), 0);
    if (chk_dur)
      chk(low_cnt == (n + 1) * div, "R9 select duration", low_cnt, (n + 1) * div);
  endtask

  task automatic idle_for(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(cs_n && !busy, req, {cs_n, busy}, 2'b10);
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !rx_valid && io_oe == 4'b1101 && ent_ready,
        "R8 reset state", {cs_n, sclk, busy, rx_valid, io_oe}, {4'b1000, 4'b1101});

    // fast read: command, address, dummy in four lanes, four-lane read
    push_ent(mk(1, 0, 0, 1, 2'b01, 8'h6B));
    push_ent(mk(1, 0, 0, 1, 2'b01, 8'h12));
    push_ent(mk(1, 0, 0, 1, 2'b01, 8'h34));
    push_ent(mk(1, 0, 0, 1, 2'b01, 8'h56));
    push_ent(mk(1, 1, 0, 0, 2'b11, 8'd1));
    push_ent(mk(0, 0, 1, 0, 2'b11, 8'd4));
    idle_for(20, "R1 queue write does not start");
    start_run(4, 1, 0, 0);

    // one-lane dummy, one-lane read, two-lane transmit, dummy and read
    push_ent(mk(1, 0, 0, 1, 2'b01, 8'h3B));
    push_ent(mk(1, 1, 0, 0, 2'b01, 8'd1));
    push_ent(mk(1, 0, 1, 0, 2'b01, 8'd2));
    push_ent(mk(1, 0, 0, 1, 2'b10, 8'hC9));
    push_ent(mk(1, 1, 0, 0, 2'b10, 8'd2));
    push_ent(mk(0, 0, 1, 0, 2'b10, 8'd3));
    start_run(2, 1, 0, 0);

    // R3 argument 0 means 256 dummy bytes
    push_ent(mk(0, 1, 0, 0, 2'b11, 8'd0));
    start_run(2, 1, 0, 0);

    // R12 start with empty queue
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    idle_for(10, "R12 empty start ignored");

    // R10 hold clear splits runs; R12 start while busy ignored
    push_ent(mk(0, 0, 0, 1, 2'b01, 8'h9F));
    push_ent(mk(0, 0, 1, 0, 2'b11, 8'd2));
    start_run(4, 1, 10, 0);
    idle_for(12, "R10 second entry waits");
    start_run(4, 1, 0, 0);

    // R11 back-pressure on receive
    push_ent(mk(0, 0, 1, 0, 2'b11, 8'd3));
    rx_ready = 1'b0;
    start_run(6, 0, 0, 40);

    // R13 lane code 00, no kind bit, kind priorities
    push_ent(mk(1, 0, 0, 1, 2'b00, 8'hA5));
    push_ent(mk(1, 0, 0, 0, 2'b11, 8'd3));
    push_ent(mk(1, 0, 1, 1, 2'b11, 8'd1));
    push_ent(mk(0, 1, 1, 0, 2'b10, 8'd1));
    start_run(2, 1, 0, 0);

    // R1 queue full
    for (int i = 0; i < 16; i++)
      push_ent(mk(i != 15, 0, 0, 1, 2'b11, 8'(i * 17)));
    @(negedge clk);
    chk(!ent_ready && cs_n, "R1 full queue", {ent_ready, cs_n}, 2'b01);
    start_run(2, 1, 0, 0);

    finish_up();
  end
endmodule